// File: doc/BRIEF.md
# Row/Column Parity Protected Word Store

This block is a small on-chip word store in which every word keeps one odd-parity bit of its own, and one register holds the exclusive-OR of all stored data words taken bit position by bit position. Writes update that column register incrementally: the old contents of the target word are XORed out and the new data XORed in. No full pass over the store is needed.

A check pass is launched with a start pulse. It walks the words in ascending order, one per clock. For each word it recomputes the odd parity and folds the data into a fresh column sum. One extra resolve cycle then compares the fresh sum with the column register. A single failing word combined with a single failing bit column marks the exact bit, and that bit is inverted in place. A single failing word with clean columns means the word's own parity bit is wrong, so that bit is rewritten. Every other failure pattern is reported as uncorrectable and the store is left alone. An injection port flips one stored bit, data or parity, without touching the column register, so that the correction paths can be exercised through the ports.

The read port is combinational. It returns the stored data of the addressed word and a flag, computed on the fly, that shows whether the word's odd parity is violated.

Top module: `hv_parity_mem`

## Requirements
- R1: After reset, every word holds all-zero data with a valid odd-parity bit (parity bit 1), the column register is zero, reads show no parity error, and done_o, err_det_o, uncorr_o, err_row_o and err_bit_o are all zero.
- R2: A write with wr_en_i high to an in-range address stores wr_data_i together with an odd-parity bit. From the next cycle, a read of that address returns the data with rd_perr_o low.
- R3: rd_perr_o is high exactly when the addressed word's data bits plus its parity bit hold an even number of ones.
- R4: With flip_en_i high and wr_en_i low, bit flip_bit_i of word flip_addr_i is inverted. Indices 0..WIDTH-1 select data bits and index WIDTH selects the parity bit. The column register is not changed.
- R5: chk_start_i while idle starts a check. On the start edge, err_det_o, uncorr_o, err_row_o and err_bit_o clear. done_o is high for exactly one cycle, WORDS+1 clock edges after the start edge. The results then hold until the next start.
- R6: If exactly one word fails its parity and exactly one column of the fresh column sum differs from the column register, that data bit is inverted in the store. err_det_o is 1, uncorr_o is 0, err_row_o gives the word and err_bit_o gives the bit position.
- R7: If exactly one word fails and no column differs, that word's parity bit is rewritten. err_det_o is 1, uncorr_o is 0, err_row_o gives the word and err_bit_o equals WIDTH.
- R8: Any other failure pattern (more than one failing word, or a column difference without exactly one failing word) sets err_det_o and uncorr_o, leaves err_row_o and err_bit_o at zero, and leaves the store unchanged.
- R9: A check over a consistent store ends with err_det_o and uncorr_o low, and err_row_o and err_bit_o at zero.
- R10: While a check is running, and on the cycle of a start taken from idle, wr_en_i, flip_en_i and chk_start_i have no effect. A write and a flip in the same cycle apply the write only.
- R11: After any sequence of overwrites, the incrementally kept column register equals the XOR of all stored data words, so a following check with no injected fault reports no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | AW | Write word index |
| wr_data_i | input | WIDTH | Write data |
| flip_en_i | input | 1 | Fault injection strobe |
| flip_addr_i | input | AW | Word to corrupt |
| flip_bit_i | input | BW | Bit to invert, WIDTH selects the parity bit |
| rd_addr_i | input | AW | Read word index |
| rd_data_o | output | WIDTH | Stored data of the addressed word |
| rd_perr_o | output | 1 | Parity violation of the addressed word |
| chk_start_i | input | 1 | Start a check pass |
| done_o | output | 1 | One-cycle pulse at the end of a check |
| err_det_o | output | 1 | Last check found a failure |
| uncorr_o | output | 1 | Last check found a failure it could not repair |
| err_row_o | output | AW | Word of the repaired bit |
| err_bit_o | output | BW | Position of the repaired bit |

## Verification
A wrong parity bit or data bit in the store is visible on the very next read of that word through rd_perr_o and rd_data_o. A wrong column register stays hidden until the next check, where it appears as a spurious column failure and therefore as an uncorrectable or misplaced repair. A sequencer that is off by one cycle shows up directly as a done_o pulse on the wrong edge. A repair applied to the wrong bit shows up on a read-back after done_o as a parity error or altered data. The bench mirrors the store, the column register and the pass timing behaviourally, and compares every output on every clock.

// File: rtl/hvp_pkg.sv
package hvp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SCAN    = 2'd1,
    ST_RESOLVE = 2'd2
  } scan_st_e;
endpackage

// File: rtl/hvp_store.sv
module hvp_store #(
  parameter int WORDS = 10,
  parameter int WIDTH = 8,
  parameter int AW    = 4,
  parameter int BW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             flip_en_i,
  input  logic [AW-1:0]    flip_addr_i,
  input  logic [BW-1:0]    flip_bit_i,
  input  logic             fix_en_i,
  input  logic [AW-1:0]    fix_row_i,
  input  logic [BW-1:0]    fix_bit_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_perr_o,
  input  logic [AW-1:0]    scan_addr_i,
  output logic [WIDTH:0]   scan_cell_o,
  output logic [WIDTH-1:0] col_o
);
  localparam int CW = WIDTH + 1;

  // bit WIDTH of each cell is the odd-parity bit
  logic [CW-1:0]    cell_q [WORDS];
  logic [WIDTH-1:0] col_q;
  logic             wr_ok, rd_ok, scan_ok, flip_ok, fix_ok;
  logic [CW-1:0]    flip_mask, fix_mask, rd_cell, old_cell;

  assign wr_ok   = wr_en_i && (int'(wr_addr_i) < WORDS);
  assign rd_ok   = int'(rd_addr_i) < WORDS;
  assign scan_ok = int'(scan_addr_i) < WORDS;
  assign flip_ok = flip_en_i && (int'(flip_addr_i) < WORDS) && (int'(flip_bit_i) <= WIDTH);
  assign fix_ok  = fix_en_i && (int'(fix_row_i) < WORDS) && (int'(fix_bit_i) <= WIDTH);

  assign flip_mask = CW'(1) << flip_bit_i;
  assign fix_mask  = CW'(1) << fix_bit_i;

  generate
    for (genvar r = 0; r < WORDS; r++) begin : g_row
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cell_q[r] <= {1'b1, {WIDTH{1'b0}}};
        end else if (wr_ok && wr_addr_i == AW'(r)) begin
          cell_q[r] <= {~^wr_data_i, wr_data_i};
        end else if (fix_ok && fix_row_i == AW'(r)) begin
          cell_q[r] <= cell_q[r] ^ fix_mask;
        end else if (flip_ok && flip_addr_i == AW'(r)) begin
          cell_q[r] <= cell_q[r] ^ flip_mask;
        end
      end
    end
  endgenerate

  assign old_cell = wr_ok ? cell_q[wr_addr_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    col_q <= '0;
    else if (wr_ok) col_q <= col_q ^ old_cell[WIDTH-1:0] ^ wr_data_i;
  end

  assign rd_cell     = rd_ok ? cell_q[rd_addr_i] : {1'b1, {WIDTH{1'b0}}};
  assign rd_data_o   = rd_cell[WIDTH-1:0];
  assign rd_perr_o   = ~^rd_cell;
  assign scan_cell_o = scan_ok ? cell_q[scan_addr_i] : {1'b1, {WIDTH{1'b0}}};
  assign col_o       = col_q;

  // a repair is only requested for a word whose parity is broken
  p_fix_bad_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_ok |-> !(^cell_q[fix_row_i]));

  // after the repair the word satisfies odd parity
  p_fix_heals_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_ok |=> (^cell_q[$past(fix_row_i)]));

  // injection never moves the column register
  p_flip_keeps_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_ok && !wr_ok) |=> $stable(col_q));
endmodule

// File: rtl/hvp_scan.sv
module hvp_scan
  import hvp_pkg::*;
#(
  parameter int WORDS = 10,
  parameter int WIDTH = 8,
  parameter int AW    = 4,
  parameter int BW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [AW-1:0]    scan_addr_o,
  input  logic [WIDTH:0]   scan_cell_i,
  input  logic [WIDTH-1:0] col_i,
  output logic             fix_en_o,
  output logic [AW-1:0]    fix_row_o,
  output logic [BW-1:0]    fix_bit_o,
  output logic             done_o,
  output logic             err_det_o,
  output logic             uncorr_o,
  output logic [AW-1:0]    err_row_o,
  output logic [BW-1:0]    err_bit_o
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  scan_st_e         st_q;
  logic [AW-1:0]    idx_q, row_q;
  logic [WIDTH-1:0] acc_q, syn;
  logic [1:0]       nrow_q, ncol;
  logic [BW-1:0]    colpos;
  logic             row_bad, start_go, clean, fixable;

  assign start_go = start_i && (st_q == ST_IDLE);
  assign busy_o   = st_q != ST_IDLE;
  assign row_bad  = !(^scan_cell_i);
  assign scan_addr_o = idx_q;
  assign syn = acc_q ^ col_i;

  // saturating column-failure count and lowest failing column
  always_comb begin
    ncol   = 2'd0;
    colpos = '0;
    for (int b = WIDTH - 1; b >= 0; b--) begin
      if (syn[b]) begin
        colpos = BW'(b);
        if (ncol != 2'd2) ncol = ncol + 2'd1;
      end
    end
  end

  assign clean     = (nrow_q == 2'd0) && (ncol == 2'd0);
  assign fixable   = (nrow_q == 2'd1) && (ncol != 2'd2);
  assign fix_en_o  = (st_q == ST_RESOLVE) && fixable;
  assign fix_row_o = row_q;
  assign fix_bit_o = (ncol == 2'd1) ? colpos : BW'(WIDTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      row_q     <= '0;
      acc_q     <= '0;
      nrow_q    <= '0;
      done_o    <= 1'b0;
      err_det_o <= 1'b0;
      uncorr_o  <= 1'b0;
      err_row_o <= '0;
      err_bit_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q      <= ST_SCAN;
            idx_q     <= '0;
            acc_q     <= '0;
            nrow_q    <= '0;
            row_q     <= '0;
            err_det_o <= 1'b0;
            uncorr_o  <= 1'b0;
            err_row_o <= '0;
            err_bit_o <= '0;
          end
        end
        ST_SCAN: begin
          acc_q <= acc_q ^ scan_cell_i[WIDTH-1:0];
          if (row_bad) begin
            if (nrow_q == 2'd0) row_q <= idx_q;
            if (nrow_q != 2'd2) nrow_q <= nrow_q + 2'd1;
          end
          if (idx_q == LAST) st_q <= ST_RESOLVE;
          else               idx_q <= idx_q + AW'(1);
        end
        ST_RESOLVE: begin
          st_q      <= ST_IDLE;
          done_o    <= 1'b1;
          err_det_o <= !clean;
          uncorr_o  <= !clean && !fixable;
          if (fixable) begin
            err_row_o <= row_q;
            err_bit_o <= fix_bit_o;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_go |=> (!err_det_o && !uncorr_o && !done_o));

  p_scan_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SCAN) |-> (int'(idx_q) < WORDS));

  p_uncorr_implies_det_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> err_det_o);

  p_uncorr_no_loc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> (err_row_o == '0 && err_bit_o == '0));
endmodule

// File: rtl/hv_parity_mem.sv
module hv_parity_mem #(
  parameter int WORDS = 10,
  parameter int WIDTH = 8,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BW   = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             flip_en_i,
  input  logic [AW-1:0]    flip_addr_i,
  input  logic [BW-1:0]    flip_bit_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_perr_o,
  input  logic             chk_start_i,
  output logic             done_o,
  output logic             err_det_o,
  output logic             uncorr_o,
  output logic [AW-1:0]    err_row_o,
  output logic [BW-1:0]    err_bit_o
);
  logic             busy, wr_go, flip_go;
  logic             fix_en;
  logic [AW-1:0]    fix_row, scan_addr;
  logic [BW-1:0]    fix_bit;
  logic [WIDTH:0]   scan_cell;
  logic [WIDTH-1:0] col;

  // start from idle wins; write wins over flip; nothing lands during a pass
  assign wr_go   = wr_en_i && !busy && !chk_start_i;
  assign flip_go = flip_en_i && !wr_en_i && !busy && !chk_start_i;

  hvp_store #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW), .BW(BW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_go),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .flip_en_i   (flip_go),
    .flip_addr_i (flip_addr_i),
    .flip_bit_i  (flip_bit_i),
    .fix_en_i    (fix_en),
    .fix_row_i   (fix_row),
    .fix_bit_i   (fix_bit),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .rd_perr_o   (rd_perr_o),
    .scan_addr_i (scan_addr),
    .scan_cell_o (scan_cell),
    .col_o       (col)
  );

  hvp_scan #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW), .BW(BW)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (chk_start_i),
    .busy_o      (busy),
    .scan_addr_o (scan_addr),
    .scan_cell_i (scan_cell),
    .col_i       (col),
    .fix_en_o    (fix_en),
    .fix_row_o   (fix_row),
    .fix_bit_o   (fix_bit),
    .done_o      (done_o),
    .err_det_o   (err_det_o),
    .uncorr_o    (uncorr_o),
    .err_row_o   (err_row_o),
    .err_bit_o   (err_bit_o)
  );

  p_busy_blocks_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !wr_go && !flip_go);

  p_done_ends_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy);
endmodule

// File: tb/hv_parity_mem_tb_top.sv
module hv_parity_mem_tb_top;
  localparam int WORDS = 10;
  localparam int WIDTH = 8;
  localparam int AW = 4;
  localparam int BW = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0, flip_en = 1'b0, chk_start = 1'b0;
  logic [AW-1:0]    wr_addr = '0, flip_addr = '0, rd_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [BW-1:0]    flip_bit = '0;
  logic [WIDTH-1:0] rd_data;
  logic             rd_perr, done, err_det, uncorr;
  logic [AW-1:0]    err_row;
  logic [BW-1:0]    err_bit;

  int n_chk = 0, n_bad = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  hv_parity_mem #(.WORDS(WORDS), .WIDTH(WIDTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .flip_en_i(flip_en), .flip_addr_i(flip_addr), .flip_bit_i(flip_bit),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_perr_o(rd_perr),
    .chk_start_i(chk_start), .done_o(done), .err_det_o(err_det),
    .uncorr_o(uncorr), .err_row_o(err_row), .err_bit_o(err_bit)
  );

  // behavioural reference
  logic [WIDTH:0]   m_cell [WORDS];
  logic [WIDTH-1:0] m_col;
  bit               m_busy, m_done, m_det, m_unc;
  int               m_cnt, m_row, m_bit;

  task automatic m_resolve();
    int nr, rr, nc, cb;
    logic [WIDTH-1:0] s;
    nr = 0; rr = 0; s = m_col;
    for (int w = 0; w < WORDS; w++) begin
      s = s ^ m_cell[w][WIDTH-1:0];
      if ($countones(m_cell[w]) % 2 == 0) begin
        if (nr == 0) rr = w;
        nr++;
      end
    end
    nc = $countones(s);
    cb = WIDTH;
    for (int b = WIDTH - 1; b >= 0; b--) if (s[b]) cb = b;
    m_done = 1;
    m_det = (nr != 0) || (nc != 0);
    if (nr == 1 && nc <= 1) begin
      m_unc = 0; m_row = rr; m_bit = cb;
      m_cell[rr][cb] = ~m_cell[rr][cb];
    end else begin
      m_unc = m_det; m_row = 0; m_bit = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) m_cell[w] = {1'b1, {WIDTH{1'b0}}};
      m_col = '0; m_busy = 0; m_done = 0; m_det = 0; m_unc = 0;
      m_cnt = 0; m_row = 0; m_bit = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (chk_start) begin
          m_busy = 1; m_cnt = 0; m_det = 0; m_unc = 0; m_row = 0; m_bit = 0;
        end else if (wr_en) begin
          if (wr_addr < WORDS) begin
            m_col = m_col ^ m_cell[wr_addr][WIDTH-1:0] ^ wr_data;
            m_cell[wr_addr] = {~^wr_data, wr_data};
          end
        end else if (flip_en) begin
          if (flip_addr < WORDS && flip_bit <= WIDTH)
            m_cell[flip_addr][flip_bit] = ~m_cell[flip_addr][flip_bit];
        end
      end else begin
        m_cnt++;
        if (m_cnt == WORDS + 1) begin
          m_resolve();
          m_busy = 0;
        end
      end
    end
  end

  task automatic chk(string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("rd_data", rd_data, m_cell[rd_addr][WIDTH-1:0]);
    chk("rd_perr", rd_perr, ($countones(m_cell[rd_addr]) % 2 == 0));
    chk("done", done, m_done);
    chk("err_det", err_det, m_det);
    chk("uncorr", uncorr, m_unc);
    chk("err_row", err_row, m_row);
    chk("err_bit", err_bit, m_bit);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic do_write(int a, int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = WIDTH'(d);
    tick();
    wr_en = 0;
  endtask

  task automatic do_flip(int a, int b);
    flip_en = 1; flip_addr = AW'(a); flip_bit = BW'(b);
    tick();
    flip_en = 0;
  endtask

  task automatic sweep();
    for (int a = 0; a < WORDS; a++) begin
      rd_addr = AW'(a);
      tick();
    end
  endtask

  task automatic run_check();
    chk_start = 1;
    tick();
    chk_start = 0;
    for (int i = 0; i < WORDS + 2; i++) begin
      rd_addr = AW'(i % WORDS);
      tick();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare();
    phase = "R1";
    sweep();

    phase = "R2";
    for (int a = 0; a < WORDS; a++) do_write(a, (a * 37 + 5) & 8'hff);
    sweep();

    phase = "R9";
    run_check();

    phase = "R4";
    rd_addr = 4;
    do_flip(4, 4);
    phase = "R3";
    tick();

    phase = "R6";
    run_check();
    sweep();

    phase = "R7";
    rd_addr = 7;
    do_flip(7, WIDTH);
    run_check();
    sweep();

    phase = "R8";
    do_flip(2, 1);
    do_flip(2, 6);
    run_check();
    sweep();
    do_flip(2, 1);
    do_flip(2, 6);
    do_flip(1, 0);
    do_flip(5, 3);
    run_check();
    sweep();
    do_flip(1, 0);
    do_flip(5, 3);

    phase = "R10";
    chk_start = 1; wr_en = 1; wr_addr = 3; wr_data = 8'hee;
    tick();
    wr_en = 0;
    flip_en = 1; flip_addr = 6; flip_bit = 2;
    tick();
    flip_en = 0;
    wr_en = 1; wr_addr = 0; wr_data = 8'h11;
    tick();
    wr_en = 0; chk_start = 0;
    for (int i = 0; i < WORDS + 2; i++) begin
      rd_addr = AW'(i % WORDS);
      tick();
    end
    wr_en = 1; flip_en = 1; wr_addr = 6; wr_data = 8'h3c; flip_addr = 6; flip_bit = 0;
    tick();
    wr_en = 0; flip_en = 0;
    sweep();

    phase = "R11";
    for (int k = 0; k < 25; k++) do_write((k * 7) % WORDS, (k * 91 + 13) & 8'hff);
    run_check();
    sweep();

    repeat (3) tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule